// File: doc/BRIEF.md
# Presettable Down Counter with Zero Detect

This block is an eight-stage synchronous down counter with a terminal-count flag. A build parameter picks how the stages count: either as one plain binary word or as two cascaded decimal digits. The count steps down by one on each rising clock edge while counting is enabled. On reaching zero it wraps to the largest value the mode can hold. The count can be loaded from a jam word in two ways: asynchronously, at once, or synchronously, on the next edge. An asynchronous clear sets the count to its maximum.

Every control input is active-low. The zero-detect output is also active-low. It is gated by the count-enable input, so several counters can be chained by wiring each stage's zero-detect output to the enable input of the next stage. The next stage then steps on the same edge at which the previous stage wraps. The current count is always visible at the outputs.

Top module: `pdc_counter`

## Requirements
- R1: In binary mode, with all controls inactive and `cin_n` low, each rising edge lowers `count_o` by one. The value 0 is followed by 255, so a free-running cycle is 256 clocks long.
- R2: In decimal mode, bits 3..0 hold the units digit and bits 7..4 hold the tens digit. Each enabled edge lowers the units digit. When the units digit is 0 it becomes 9 and the tens digit is lowered. The value 0x00 is followed by 0x99, so a free-running cycle is 100 clocks long.
- R3: In decimal mode, a digit holding 10 to 15 steps down by one per borrow, like a binary nibble, until it is back in the range 0 to 9. For example, 0xFC is followed by 0xFB, and 0xA0 is followed by 0x99.
- R4: With `cin_n` high and no load or clear active, clock edges leave the count unchanged.
- R5: With `spre_n` low, the next rising edge loads `jam_i`, whatever the level of `cin_n`.
- R6: While `apre_n` is low, `count_o` equals `jam_i` at once, without a clock edge, and follows changes of `jam_i`. This overrides `spre_n`, `cin_n` and the clock.
- R7: While `clr_n` is low, `count_o` is the mode maximum (255 binary, 0x99 decimal) at once. This overrides every other input.
- R8: `zd_n` is low exactly when `count_o` is zero and `cin_n` is low. It responds combinationally to both, so a stage can drive the `cin_n` input of the next stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge |
| clr_n | input | 1 | Asynchronous clear to maximum, active-low, top priority |
| apre_n | input | 1 | Asynchronous load of jam word, active-low |
| spre_n | input | 1 | Synchronous load of jam word, active-low |
| cin_n | input | 1 | Carry-in / count enable, active-low |
| jam_i | input | 8 | Load value (two decimal digits in decimal mode) |
| count_o | output | 8 | Current count |
| zd_n | output | 1 | Zero detect / carry-out, active-low |

## Verification
The two functions most likely to meet in one cycle are a load and a count step. This happens when a synchronous or asynchronous load arrives on the same edge at which the count would wrap from zero, and when clear and asynchronous preset are held together. Random stimulus sets all four controls independently each cycle, with low rates for the strong controls, so these overlaps occur often. Directed steps also force clear and asynchronous preset together in mid-cycle. Each outcome is compared, both right after the inputs change and after the following edge, with a bench model that applies the priority clear > asynchronous preset > synchronous preset > count.

// File: rtl/pdc_pkg.sv
// Package: shared types for the presettable down counter.
// Assumes: digits are four bits wide; decimal digits use the values 0..9.
package pdc_pkg;
    typedef enum logic {
        CNT_BINARY = 1'b0,
        CNT_DECADE = 1'b1
    } cnt_mode_e;

    localparam int DIGIT_W   = 4;
    localparam int DIGIT_TOP = 9;
endpackage

// File: rtl/pdc_digit.sv
// Module: one decimal digit of the down-count chain.
// Lowers the digit by one when a borrow comes in. Zero wraps to nine and
// passes the borrow on. Values 10..15 step down like a binary nibble.
// Assumes: purely combinational; the caller registers the result.
module pdc_digit #(
    parameter int W = pdc_pkg::DIGIT_W
) (
    input  logic [W-1:0] d_i,
    input  logic         borrow_i,
    output logic [W-1:0] d_o,
    output logic         borrow_o
);
    localparam logic [W-1:0] TOP = W'(pdc_pkg::DIGIT_TOP);

    // digit step: hold, wrap to nine, or subtract one
    always_comb begin
        borrow_o = borrow_i && (d_i == '0);
        if (!borrow_i)
            d_o = d_i;
        else if (d_i == '0)
            d_o = TOP;
        else
            d_o = d_i - W'(1);
    end
endmodule

// File: rtl/pdc_step.sv
// Module: next count value for one enabled decrement.
// Binary mode subtracts one with natural wrap. Decimal mode chains digit
// cells, and the units digit always receives a borrow.
// Assumes: counter width is DIGITS * DIGIT_W.
module pdc_step #(
    parameter pdc_pkg::cnt_mode_e MODE   = pdc_pkg::CNT_BINARY,
    parameter int                 DIGITS = 2,
    localparam int                W      = DIGITS * pdc_pkg::DIGIT_W
) (
    input  logic [W-1:0] cnt_i,
    output logic [W-1:0] nxt_o
);
    localparam int DW = pdc_pkg::DIGIT_W;

    generate
        if (MODE == pdc_pkg::CNT_BINARY) begin : g_bin
            // binary step: modulo-2^W subtract
            always_comb nxt_o = cnt_i - W'(1);
        end else begin : g_dec
            logic [DIGITS:0] borrow;
            assign borrow[0] = 1'b1;
            for (genvar i = 0; i < DIGITS; i++) begin : g_dig
                pdc_digit #(.W(DW)) dig_i (
                    .d_i      (cnt_i[i*DW +: DW]),
                    .borrow_i (borrow[i]),
                    .d_o      (nxt_o[i*DW +: DW]),
                    .borrow_o (borrow[i+1])
                );
            end
        end
    endgenerate
endmodule

// File: rtl/pdc_zero.sv
// Module: gated zero detect, active-low.
// Assumes: combinational, so a cascaded stage sees it in the same cycle.
module pdc_zero #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt_i,
    input  logic         cin_n_i,
    output logic         zd_n_o
);
    // flag zero only while counting is enabled
    always_comb zd_n_o = !((cnt_i == '0) && !cin_n_i);
endmodule

// File: rtl/pdc_counter.sv
// Module: presettable down counter with zero detect (top).
// Priority: clear > asynchronous preset > synchronous preset > count.
// Clear and asynchronous preset act on the register and on the visible
// count at once. Clear loads the mode maximum.
// Assumes: clr_n is the block's only reset and is asynchronous by intent.
module pdc_counter #(
    parameter pdc_pkg::cnt_mode_e MODE   = pdc_pkg::CNT_BINARY,
    parameter int                 DIGITS = 2,
    localparam int                W      = DIGITS * pdc_pkg::DIGIT_W
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         apre_n,
    input  logic         spre_n,
    input  logic         cin_n,
    input  logic [W-1:0] jam_i,
    output logic [W-1:0] count_o,
    output logic         zd_n
);
    localparam int DW = pdc_pkg::DIGIT_W;

    function automatic logic [W-1:0] max_count();
        logic [W-1:0] r;
        r = '1;
        if (MODE == pdc_pkg::CNT_DECADE)
            for (int i = 0; i < DIGITS; i++)
                r[i*DW +: DW] = DW'(pdc_pkg::DIGIT_TOP);
        return r;
    endfunction

    localparam logic [W-1:0] MAXV = max_count();

    logic [W-1:0] cnt_q;
    logic [W-1:0] step_w;

    pdc_step #(.MODE(MODE), .DIGITS(DIGITS)) step_i (
        .cnt_i (cnt_q),
        .nxt_o (step_w)
    );

    // count register: asynchronous clear/preset, then synchronous load or step
    always_ff @(posedge clk or negedge clr_n or negedge apre_n) begin
        if (!clr_n)
            cnt_q <= MAXV;
        else if (!apre_n)
            cnt_q <= jam_i;
        else if (!spre_n)
            cnt_q <= jam_i;
        else if (!cin_n)
            cnt_q <= step_w;
    end

    // visible count: asynchronous controls act at once, even while jam moves
    always_comb begin
        if (!clr_n)
            count_o = MAXV;
        else if (!apre_n)
            count_o = jam_i;
        else
            count_o = cnt_q;
    end

    pdc_zero #(.W(W)) zero_i (
        .cnt_i   (count_o),
        .cin_n_i (cin_n),
        .zd_n_o  (zd_n)
    );

    // R7
    clr_max_chk: assert property (@(posedge clk) !clr_n |-> (cnt_q == MAXV));

    // R6
    apre_load_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !apre_n |=> (cnt_q == $past(jam_i)));

    // R5
    spre_load_chk: assert property (@(posedge clk) disable iff (!clr_n || !apre_n)
        !spre_n |=> (cnt_q == $past(jam_i)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!clr_n || !apre_n)
        (spre_n && cin_n) |=> $stable(cnt_q));

    // R8
    zd_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n || !apre_n)
        (!zd_n && spre_n) |=> (cnt_q == MAXV));

    generate
        if (MODE == pdc_pkg::CNT_BINARY) begin : g_bin_chk
            // R1
            bin_dec_chk: assert property (@(posedge clk) disable iff (!clr_n || !apre_n)
                (spre_n && !cin_n && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
        end
    endgenerate
endmodule

// File: tb/pdc_counter_tb_top.sv
`timescale 1ns/1ps
// Bench: decimal instance dut_i and binary instance dut_b_i share inputs.
// Both are checked against bench-computed models every cycle.
module pdc_counter_tb_top;
    logic       clk = 1'b0;
    logic       clr_n, apre_n, spre_n, cin_n;
    logic [7:0] jam;
    logic [7:0] cnt_d, cnt_b;
    logic       zd_d, zd_b;
    logic [7:0] md, mb;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    pdc_counter #(.MODE(pdc_pkg::CNT_DECADE), .DIGITS(2)) dut_i (
        .clk(clk), .clr_n(clr_n), .apre_n(apre_n), .spre_n(spre_n),
        .cin_n(cin_n), .jam_i(jam), .count_o(cnt_d), .zd_n(zd_d));

    pdc_counter #(.MODE(pdc_pkg::CNT_BINARY), .DIGITS(2)) dut_b_i (
        .clk(clk), .clr_n(clr_n), .apre_n(apre_n), .spre_n(spre_n),
        .cin_n(cin_n), .jam_i(jam), .count_o(cnt_b), .zd_n(zd_b));

    function automatic logic [3:0] dig_dn(input logic [3:0] d);
        return (d == 4'd0) ? 4'd9 : d - 4'd1;
    endfunction

    function automatic logic [7:0] dec_dn(input logic [7:0] v);
        logic [3:0] t;
        t = (v[3:0] == 4'd0) ? dig_dn(v[7:4]) : v[7:4];
        return {t, dig_dn(v[3:0])};
    endfunction

    // reference registers, updated with the priority rule
    always @(posedge clk) begin
        if (!clr_n) begin
            md <= 8'h99; mb <= 8'hFF;
        end else if (!apre_n || !spre_n) begin
            md <= jam; mb <= jam;
        end else if (!cin_n) begin
            md <= dec_dn(md); mb <= mb - 8'd1;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        logic [7:0] vd, vb;
        vd = !clr_n ? 8'h99 : (!apre_n ? jam : md);
        vb = !clr_n ? 8'hFF : (!apre_n ? jam : mb);
        chk("R2 decimal count", cnt_d, vd);
        chk("R1 binary count", cnt_b, vb);
        chk("R8 zero detect decimal", {7'd0, zd_d}, {7'd0, !(vd == 8'h00 && !cin_n)});
        chk("R8 zero detect binary", {7'd0, zd_b}, {7'd0, !(vb == 8'h00 && !cin_n)});
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        clr_n = 1'b1; apre_n = 1'b1; spre_n = 1'b1; cin_n = 1'b1; jam = 8'h00;
        #1 clr_n = 1'b0;
        tick();
        chk("R7 clear decimal", cnt_d, 8'h99);
        chk("R7 clear binary", cnt_b, 8'hFF);

        // R5: synchronous load while counting is held
        clr_n = 1'b1; spre_n = 1'b0; jam = 8'h37;
        tick();
        chk("R5 load decimal", cnt_d, 8'h37);
        chk("R5 load binary", cnt_b, 8'h37);
        // R4: hold
        spre_n = 1'b1;
        tick(); tick();
        chk("R4 hold binary", cnt_b, 8'h37);
        chk("R4 hold decimal", cnt_d, 8'h37);
        cin_n = 1'b0;
        tick();
        chk("R1 step binary", cnt_b, 8'h36);
        chk("R2 step decimal", cnt_d, 8'h36);
        spre_n = 1'b0; jam = 8'h30;
        tick();
        spre_n = 1'b1;
        tick();
        chk("R2 borrow decimal", cnt_d, 8'h29);
        chk("R1 borrow binary", cnt_b, 8'h2F);

        // R8: zero flag and its gating
        spre_n = 1'b0; jam = 8'h00;
        tick();
        chk("R8 zero flag decimal", {7'd0, zd_d}, 8'd0);
        chk("R8 zero flag binary", {7'd0, zd_b}, 8'd0);
        spre_n = 1'b1; cin_n = 1'b1;
        #1 chk("R8 gated by enable", {7'd0, zd_b}, 8'd1);
        cin_n = 1'b0;
        #1 chk("R8 enable restores flag", {7'd0, zd_d}, 8'd0);
        tick();
        chk("R1 wrap binary", cnt_b, 8'hFF);
        chk("R2 wrap decimal", cnt_d, 8'h99);

        // R3: invalid decimal digits
        spre_n = 1'b0; jam = 8'hFC;
        tick();
        spre_n = 1'b1;
        tick();
        chk("R3 invalid units", cnt_d, 8'hFB);
        tick(); tick(); tick();
        chk("R3 invalid units settle", cnt_d, 8'hF8);
        spre_n = 1'b0; jam = 8'hA0;
        tick();
        spre_n = 1'b1;
        tick();
        chk("R3 invalid tens", cnt_d, 8'h99);

        // R6: asynchronous preset, mid-cycle and transparent
        apre_n = 1'b0; spre_n = 1'b0; jam = 8'h5A;
        #1 chk("R6 async decimal", cnt_d, 8'h5A);
        chk("R6 async binary", cnt_b, 8'h5A);
        jam = 8'h11;
        #1 chk("R6 follows jam", cnt_b, 8'h11);
        tick();
        apre_n = 1'b1; spre_n = 1'b1;
        tick();
        chk("R6 then count", cnt_b, 8'h10);

        // R7: clear overrides asynchronous preset
        clr_n = 1'b0; apre_n = 1'b0; spre_n = 1'b0;
        #1 chk("R7 over preset decimal", cnt_d, 8'h99);
        chk("R7 over preset binary", cnt_b, 8'hFF);
        tick();
        clr_n = 1'b1; apre_n = 1'b1;
        jam = 8'h00;
        tick();
        spre_n = 1'b1;

        // free run: decimal period 100, binary period 256
        for (int i = 0; i < 100; i++) tick();
        chk("R2 period 100", cnt_d, 8'h00);
        for (int i = 0; i < 156; i++) tick();
        chk("R1 period 256", cnt_b, 8'h00);

        // constrained random mix of all controls
        for (int i = 0; i < 4000; i++) begin
            clr_n  = ($urandom % 40) != 0;
            apre_n = ($urandom % 24) != 0;
            spre_n = ($urandom % 10) != 0;
            cin_n  = ($urandom % 4) == 0;
            jam    = 8'($urandom);
            #1 check_all();
            tick();
        end
        finish_run();
    end
endmodule